// File: doc/BRIEF.md
# Listener byte handshake with ready-for-data holdoff

This block is the receiving end of a three-wire interlocked byte handshake on an eight-bit parallel instrument bus. A talker raises data-valid. The block answers through two lines: not-ready-for-data and not-data-accepted. When a byte arrives it is latched into a receive register and a byte-in flag is raised. The block keeps not-ready-for-data asserted until the host has read the byte. All bus lines are modelled as active-high internal signals; the open-collector drivers sit outside the block. Data-valid passes through a synchronizer before the state machine sees it.

The host can hold off the next ready-for-data in one of two ways. In hold-all mode every byte is held. In hold-end mode only a byte that ends a message is held, that is, one received with end-or-identify asserted and attention negated. A one-cycle release strobe ends the holdoff. Such an end byte also sets a sticky end flag, which the host clears with a status-read strobe. A shadow mode runs the handshake without taking the byte. In this mode not-data-accepted is released within three clocks of data-valid, and not-ready-for-data is released once data-valid has gone away. The three mode bits are loaded together through a configuration strobe.

Top module: `bus_acceptor`

## Requirements
- R1: A synchronous reset sets nrfd_out=1, ndac_out=1, bi_flag=0 and end_flag=0, and clears all three mode bits. On the first clock edge after reset is released with dav_in low, nrfd_out falls to 0.
- R2: With shadow mode off, dav_in rises while ready. With the default two-stage synchronizer, nrfd_out is 1 after the third edge. After the fourth edge rx_byte holds dio_in, bi_flag=1 and ndac_out=0.
- R3: nrfd_out stays 1 while bi_flag is 1. A host read (host_cs=1, host_we=0 for one cycle) clears bi_flag at the next edge.
- R4: With no holdoff pending and dav_in already low, nrfd_out returns to 0 and ndac_out to 1 on the third edge after a read strobe.
- R5: With cfg_mode bit 0 (hold-all) set, every captured byte leaves nrfd_out at 1 after the read. Only a rel_pulse strobe ends this, and nrfd_out falls on the third edge after that strobe.
- R6: With cfg_mode bit 1 (hold-end) set, a holdoff as in R5 occurs only for a byte captured with eoi_in=1 and atn_in=0. Any other byte completes as in R4.
- R7: A byte captured with eoi_in=1 and atn_in=0 sets end_flag at the same edge as bi_flag. A byte with atn_in=1 does not set it. stat_rd clears end_flag at the next edge.
- R8: With cfg_mode bit 2 (shadow) set, ndac_out falls on the third edge after dav_in rises. bi_flag, end_flag and rx_byte are unchanged. nrfd_out returns to 0 on the third edge after dav_in falls.
- R9: A host write (host_cs=1, host_we=1) leaves rx_byte and bi_flag unchanged.
- R10: rel_pulse has no effect when no holdoff is pending: bi_flag and nrfd_out keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dav_in | input | 1 | Data-valid from the talker, asynchronous |
| eoi_in | input | 1 | End-or-identify line, stable while data-valid is asserted |
| atn_in | input | 1 | Attention line, stable while data-valid is asserted |
| dio_in | input | DATA_W | Data lines |
| host_cs | input | 1 | Host access strobe for the receive register address |
| host_we | input | 1 | 1 = write access (ignored here), 0 = read access |
| stat_rd | input | 1 | Status read strobe, clears end_flag |
| rel_pulse | input | 1 | One-cycle release of a ready-for-data holdoff |
| cfg_we | input | 1 | Loads cfg_mode into the mode register |
| cfg_mode | input | 3 | Bit 0 hold-all, bit 1 hold-end, bit 2 shadow |
| nrfd_out | output | 1 | Not-ready-for-data, 1 = asserted |
| ndac_out | output | 1 | Not-data-accepted, 1 = asserted |
| rx_byte | output | DATA_W | Received byte |
| bi_flag | output | 1 | Byte-in flag |
| end_flag | output | 1 | Sticky end-byte flag |

## Verification
Each result has a fixed latency that counts every register on its path. Captures appear four edges after data-valid rises: two synchronizer stages, the accept state, then the latch. Host reads and status reads clear their flag one edge later. Ready-for-data returns three edges after the last enabling strobe or after data-valid falls. When the bench drives a stimulus, it records the cycle number and queues each expected value with its due cycle. The monitor compares only in that cycle, at the falling clock edge, so a result that arrives early or late is reported as a miscompare.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READY  = 3'd1,
    ST_ACCEPT = 3'd2,
    ST_HOST   = 3'd3,
    ST_DAVOFF = 3'd4
  } acc_state_e;

  // bit 2 shadow, bit 1 hold-end, bit 0 hold-all
  typedef struct packed {
    logic shadow;
    logic hold_end;
    logic hold_all;
  } acc_mode_t;

  localparam int MODE_W = $bits(acc_mode_t);

endpackage

// File: rtl/acc_sync.sv
module acc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/acc_mode_reg.sv
module acc_mode_reg
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  output acc_mode_t         mode
);
  always_ff @(posedge clk) begin
    if (rst)         mode <= '0;
    else if (cfg_we) mode <= acc_mode_t'(cfg_mode);
  end
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dav_s,
  input  logic shadow,
  input  logic hold_req,
  input  logic release_p,
  input  logic bi,
  output logic capture,
  output logic nrfd,
  output logic ndac
);
  acc_state_e state, nxt;
  logic       pend;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (!dav_s) nxt = ST_READY;
      ST_READY:  if (dav_s)  nxt = shadow ? ST_DAVOFF : ST_ACCEPT;
      ST_ACCEPT: nxt = ST_HOST;
      ST_HOST:   if (!bi && !pend) nxt = ST_DAVOFF;
      ST_DAVOFF: if (!dav_s) nxt = ST_READY;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      nrfd  <= 1'b1;
      ndac  <= 1'b1;
    end else begin
      state <= nxt;
      if (state == ST_ACCEPT) pend <= hold_req;
      else if (release_p)     pend <= 1'b0;
      nrfd <= (nxt != ST_READY);
      ndac <= (nxt == ST_IDLE) || (nxt == ST_READY) || (nxt == ST_ACCEPT);
    end
  end

  assign capture = (state == ST_ACCEPT);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dio,
  input  logic              end_byte,
  input  logic              rd_strobe,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              bi,
  output logic              end_f
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      bi      <= 1'b0;
      end_f   <= 1'b0;
    end else begin
      if (capture)        rx_byte <= dio;
      if (capture)        bi <= 1'b1;
      else if (rd_strobe) bi <= 1'b0;
      if (capture && end_byte) end_f <= 1'b1;
      else if (stat_rd)        end_f <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_acceptor.sv
module bus_acceptor
  import acc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dav_in,
  input  logic              eoi_in,
  input  logic              atn_in,
  input  logic [DATA_W-1:0] dio_in,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic              stat_rd,
  input  logic              rel_pulse,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  output logic              nrfd_out,
  output logic              ndac_out,
  output logic [DATA_W-1:0] rx_byte,
  output logic              bi_flag,
  output logic              end_flag
);
  logic      dav_s, capture, end_byte, hold_req, rd_strobe;
  acc_mode_t mode_s;

  acc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(dav_in), .q(dav_s)
  );

  acc_mode_reg u_mode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode(mode_s)
  );

  assign end_byte  = eoi_in & ~atn_in;
  assign hold_req  = mode_s.hold_all | (mode_s.hold_end & end_byte);
  assign rd_strobe = host_cs & ~host_we;

  acc_fsm u_fsm (
    .clk(clk), .rst(rst), .dav_s(dav_s), .shadow(mode_s.shadow),
    .hold_req(hold_req), .release_p(rel_pulse), .bi(bi_flag),
    .capture(capture), .nrfd(nrfd_out), .ndac(ndac_out)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .capture(capture), .dio(dio_in),
    .end_byte(end_byte), .rd_strobe(rd_strobe), .stat_rd(stat_rd),
    .rx_byte(rx_byte), .bi(bi_flag), .end_f(end_flag)
  );
endmodule

// File: rtl/bus_acceptor_chk.sv
module bus_acceptor_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_cs,
  input logic              host_we,
  input logic              shadow_on,
  input logic              nrfd_out,
  input logic              ndac_out,
  input logic [DATA_W-1:0] rx_byte,
  input logic              bi_flag,
  input logic              end_flag
);
  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (nrfd_out && ndac_out && !bi_flag && !end_flag));

  // R2: a capture coincides with NDAC released and NRFD held
  assert_capture_lines_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bi_flag) |-> (nrfd_out && !ndac_out));

  // R3: NRFD held while a byte waits
  assert_nrfd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    bi_flag |-> nrfd_out);

  // R3: a host read clears the flag
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (bi_flag && host_cs && !host_we) |=> !bi_flag);

  // R4: ready never coexists with released NDAC
  assert_ready_ndac_R4: assert property (@(posedge clk) disable iff (rst)
    !nrfd_out |-> ndac_out);

  // R8: no capture while shadow mode has been steady
  assert_shadow_nocap_R8: assert property (@(posedge clk) disable iff (rst)
    (shadow_on && $past(shadow_on) && $past(shadow_on, 2)) |-> !$rose(bi_flag));

  // R9: a write leaves a waiting byte intact
  assert_write_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (bi_flag && host_cs && host_we) |=> ($stable(rx_byte) && bi_flag));
endmodule

bind bus_acceptor bus_acceptor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
  .shadow_on(mode_s.shadow), .nrfd_out(nrfd_out), .ndac_out(ndac_out),
  .rx_byte(rx_byte), .bi_flag(bi_flag), .end_flag(end_flag)
);

// File: tb/bus_acceptor_test.sv
`timescale 1ns/1ps
module bus_acceptor_test;
  localparam int CLK_PERIOD = 10;
  localparam int S_NRFD = 0, S_NDAC = 1, S_BI = 2, S_END = 3, S_DATA = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic       dav = 0, eoi = 0, atn = 0, cs = 0, we = 0, srd = 0, rel = 0, cwe = 0;
  logic [7:0] dio = '0;
  logic [2:0] cmode = '0;
  logic       nrfd, ndac, bi, endf;
  logic [7:0] rxb;

  int   cyc = 0;
  int   vectors = 0, miscompares = 0;
  bit   end_model = 0;
  bit   done = 0;

  int         due_q[$];
  int         sig_q[$];
  logic [7:0] val_q[$];
  string      req_q[$];

  bus_acceptor uut (
    .clk(clk), .rst(rst), .dav_in(dav), .eoi_in(eoi), .atn_in(atn), .dio_in(dio),
    .host_cs(cs), .host_we(we), .stat_rd(srd), .rel_pulse(rel),
    .cfg_we(cwe), .cfg_mode(cmode), .nrfd_out(nrfd), .ndac_out(ndac),
    .rx_byte(rxb), .bi_flag(bi), .end_flag(endf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_at(input int due, input int sig, input logic [7:0] v, input string r);
    due_q.push_back(due); sig_q.push_back(sig); val_q.push_back(v); req_q.push_back(r);
  endtask

  function automatic logic [7:0] actual(input int sig);
    case (sig)
      S_NRFD:  return {7'd0, nrfd};
      S_NDAC:  return {7'd0, ndac};
      S_BI:    return {7'd0, bi};
      S_END:   return {7'd0, endf};
      default: return rxb;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        logic [7:0] a;
        a = actual(sig_q[i]);
        vectors++;
        if (a !== val_q[i]) begin
          miscompares++;
          $display("FAIL %s cycle %0d signal %0d actual %0h expected %0h",
                   req_q[i], cyc, sig_q[i], a, val_q[i]);
        end
        due_q.delete(i); sig_q.delete(i); val_q.delete(i); req_q.delete(i);
      end
    end
  end

  task automatic set_mode(input logic [2:0] m);
    cmode = m; cwe = 1; step(); cwe = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit e, input bit a,
                           input bit sh, input string r);
    int n;
    logic [7:0] prev;
    while (nrfd !== 1'b0) step();
    prev = rxb;
    dio = d; eoi = e; atn = a; dav = 1;
    n = cyc;
    expect_at(n + 3, S_NRFD, 1, r);
    if (sh) begin
      // R8: shadow handshake, nothing captured
      expect_at(n + 3, S_NDAC, 0, "R8");
      expect_at(n + 4, S_BI,   0, "R8");
      expect_at(n + 4, S_DATA, prev, "R8");
      expect_at(n + 4, S_END,  {7'd0, end_model}, "R8");
      expect_at(n + 7, S_NRFD, 0, "R8");
      expect_at(n + 7, S_NDAC, 1, "R8");
    end else begin
      if (e && !a) end_model = 1;
      expect_at(n + 3, S_NDAC, 1, r);
      expect_at(n + 4, S_BI,   1, r);
      expect_at(n + 4, S_NDAC, 0, r);
      expect_at(n + 4, S_DATA, d, r);
      expect_at(n + 4, S_END,  {7'd0, end_model}, "R7");
    end
    while (cyc < n + 4) step();
    dav = 0; eoi = 0; atn = 0;
  endtask

  task automatic host_read(input bit held, input string r);
    int m;
    m = cyc;
    expect_at(m + 1, S_BI,   0, "R3");
    expect_at(m + 2, S_NRFD, 1, "R3");
    expect_at(m + 3, S_NRFD, held ? 8'd1 : 8'd0, r);
    expect_at(m + 3, S_NDAC, held ? 8'd0 : 8'd1, r);
    cs = 1; we = 0; step(); cs = 0;
  endtask

  task automatic release_hold(input string r);
    expect_at(cyc + 3, S_NRFD, 0, r);
    rel = 1; step(); rel = 0;
  endtask

  initial begin
    int n;
    repeat (4) step();
    rst = 0;
    n = cyc;
    // R1: reset values, then ready on the next edge
    expect_at(n, S_NRFD, 1, "R1"); expect_at(n, S_NDAC, 1, "R1");
    expect_at(n, S_BI, 0, "R1");   expect_at(n, S_END, 0, "R1");
    expect_at(n, S_DATA, 0, "R1"); expect_at(n + 1, S_NRFD, 0, "R1");
    step(); step();

    // R2 R4: plain byte
    send_byte(8'hA5, 0, 0, 0, "R2");
    host_read(0, "R4");

    // R9: write strobe while a byte waits
    send_byte(8'h3C, 0, 1, 0, "R2");
    n = cyc;
    expect_at(n + 1, S_DATA, 8'h3C, "R9");
    expect_at(n + 1, S_BI, 1, "R9");
    cs = 1; we = 1; step(); cs = 0; we = 0;
    // R10: release with no holdoff pending
    n = cyc;
    expect_at(n + 1, S_BI, 1, "R10");
    expect_at(n + 2, S_NRFD, 1, "R10");
    rel = 1; step(); rel = 0;
    host_read(0, "R4");

    // R7: end byte sets flag, status read clears it, ATN byte does not set it
    send_byte(8'h81, 1, 0, 0, "R7");
    host_read(0, "R4");
    expect_at(cyc + 1, S_END, 0, "R7");
    end_model = 0;
    srd = 1; step(); srd = 0;
    send_byte(8'h42, 1, 1, 0, "R7");
    host_read(0, "R4");

    // R5: hold on every byte
    set_mode(3'b001);
    send_byte(8'h5A, 0, 0, 0, "R5");
    host_read(1, "R5");
    repeat (3) step();
    expect_at(cyc + 1, S_NRFD, 1, "R5");
    step(); step();
    release_hold("R5");
    send_byte(8'hC3, 0, 1, 0, "R5");
    host_read(1, "R5");
    step();
    release_hold("R5");

    // R6: hold only on end byte
    set_mode(3'b010);
    send_byte(8'h11, 0, 0, 0, "R6");
    host_read(0, "R6");
    send_byte(8'h22, 1, 1, 0, "R6");
    host_read(0, "R6");
    send_byte(8'h33, 1, 0, 0, "R6");
    host_read(1, "R6");
    step(); step();
    release_hold("R6");
    expect_at(cyc + 1, S_END, 0, "R7");
    end_model = 0;
    srd = 1; step(); srd = 0;

    // R8: shadow handshake
    set_mode(3'b100);
    step();
    send_byte(8'h77, 1, 0, 1, "R8");
    send_byte(8'hEE, 0, 0, 1, "R8");
    repeat (4) step();

    // back to normal capture after shadow
    set_mode(3'b000);
    send_byte(8'h99, 0, 0, 0, "R2");
    host_read(0, "R4");

    repeat (10) step();
    if (due_q.size() != 0) begin
      miscompares += due_q.size();
      $display("FAIL %0d expectations never compared (actual pending, expected none)",
               due_q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule